// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control state machine of a 16-bit processor whose registers all meet on one shared bus. For each instruction it runs a fixed three-step fetch, decodes the opcode, and then walks through only the later phases that the opcode needs. The later phases are evaluate address, fetch operands, execute and store result. In every step it names the one source allowed to drive the bus and the registers that capture from it. It also raises the PC increment, the PC jump and the memory read request, and selects the ALU operation.

The datapath holds the instruction register and feeds its contents back on `ir`. The sequencer reads `ir` only from the decode step onward. Memory reports completion on `mem_ready`, and each memory read step waits for it. The opcode in `ir[15:12]` is decoded into sixteen one-hot lines. The register and offset fields are split out for the datapath to use.

The block recognises four instruction classes. Opcodes 1, 5 and 9 are register ALU operations. Opcodes 2 and 6 are loads, PC-relative and base-plus-offset respectively. Opcode 0 is a branch. Every other opcode finishes after decode.

Top module: `instr_seq`

## Requirements
- R1: Step code 0 (fetch 1) asserts `drv_pc`, `ld_mar` and `pc_inc`, and is always followed by step code 1.
- R2: In step code 1 (fetch 2), `mem_rd` is asserted and the state holds while `mem_ready` is 0. `ld_mdr` is asserted only in a cycle where `mem_ready` is 1, and the state then moves to step code 2.
- R3: Step code 2 (fetch 3) asserts `drv_mdr` and `ld_ir`, and is followed by step code 3 (decode).
- R4: `op_hot` has exactly one bit set, at the index given by `ir[15:12]`.
- R5: The fields are taken from `ir` as follows: `dst` = ir[11:9], `sr1` = ir[8:6], `sr2` = ir[2:0], `off6` = ir[5:0], `off9` = ir[8:0], `imm_mode` = ir[5].
- R6: For ALU opcodes (1 = add, 2'b00; 5 = and, 2'b01; 9 = not, 2'b10 on `alu_op`; every other opcode gives 2'b11), the steps after decode are 5, 6 and 7, then 0. Step 7 asserts `drv_alu`, `ld_reg` and `ld_cc`.
- R7: For loads (opcode 2 or 6), the steps after decode are 4, 5 and 7, then 0. Step 4 asserts `drv_addr` and `ld_mar`, with `addr_base` set to 1 for opcode 6 and 0 for opcode 2. Step 5 asserts `mem_rd` and waits for `mem_ready` in the same way as R2. Step 7 asserts `drv_mdr`, `ld_reg` and `ld_cc`.
- R8: For opcode 0 (branch), the steps after decode are 4 and 6, then 0. Step 6 asserts `pc_jump`.
- R9: Any other opcode returns from decode straight to step 0.
- R10: At most one of `drv_pc`, `drv_mdr`, `drv_alu` and `drv_addr` is asserted in any cycle.
- R11: While `rst_n` is low, every strobe is 0. After reset the sequencer starts at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 16 | Instruction register contents |
| mem_ready | input | 1 | Memory read complete |
| step | output | 3 | Current step code (0 to 7) |
| drv_pc | output | 1 | PC drives the bus |
| drv_mdr | output | 1 | MDR drives the bus |
| drv_alu | output | 1 | ALU result drives the bus |
| drv_addr | output | 1 | Address adder drives the bus |
| ld_mar | output | 1 | MAR captures the bus |
| ld_mdr | output | 1 | MDR captures the memory data |
| ld_ir | output | 1 | Instruction register captures the bus |
| ld_reg | output | 1 | Register file writes `dst` |
| ld_cc | output | 1 | Condition codes update |
| pc_inc | output | 1 | PC increments |
| pc_jump | output | 1 | PC loads the adder result |
| mem_rd | output | 1 | Memory read request |
| addr_base | output | 1 | Adder base: 1 = register, 0 = PC |
| alu_op | output | 2 | ALU operation select |
| op_hot | output | 16 | One-hot opcode lines |
| dst | output | 3 | Destination register field |
| sr1 | output | 3 | First source register field |
| sr2 | output | 3 | Second source register field |
| imm_mode | output | 1 | Immediate-operand flag |
| off6 | output | 6 | Six-bit offset field |
| off9 | output | 9 | Nine-bit offset field |

## Verification
A wrong state shows up on `step` in the very next cycle. It also shows on the strobes of that same cycle, as the wrong bus driver or a missing load. A wrong path choice at decode appears one clock after step 3. A stuck or skipped wait shows up as a missing or early `ld_mdr` against the `mem_ready` pattern. A miscounted return to fetch shows up as a step sequence that does not restart at 0 when the next instruction is due.

// File: rtl/instr_seq.sv
module instr_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ir,
  input  logic        mem_ready,
  output logic [2:0]  step,
  output logic        drv_pc,
  output logic        drv_mdr,
  output logic        drv_alu,
  output logic        drv_addr,
  output logic        ld_mar,
  output logic        ld_mdr,
  output logic        ld_ir,
  output logic        ld_reg,
  output logic        ld_cc,
  output logic        pc_inc,
  output logic        pc_jump,
  output logic        mem_rd,
  output logic        addr_base,
  output logic [1:0]  alu_op,
  output logic [15:0] op_hot,
  output logic [2:0]  dst,
  output logic [2:0]  sr1,
  output logic [2:0]  sr2,
  output logic        imm_mode,
  output logic [5:0]  off6,
  output logic [8:0]  off9
);

  typedef enum logic [2:0] {
    F1 = 3'd0, F2 = 3'd1, F3 = 3'd2, DEC = 3'd3,
    EA = 3'd4, OPF = 3'd5, EXE = 3'd6, STR = 3'd7
  } st_t;

  st_t st, nx;
  wire [3:0] op = ir[15:12];

  wire is_alu = (op == 4'd1) || (op == 4'd5) || (op == 4'd9);
  wire is_ld  = (op == 4'd2) || (op == 4'd6);
  wire is_br  = (op == 4'd0);

  assign op_hot   = 16'd1 << op;
  assign dst      = ir[11:9];
  assign sr1      = ir[8:6];
  assign sr2      = ir[2:0];
  assign imm_mode = ir[5];
  assign off6     = ir[5:0];
  assign off9     = ir[8:0];
  assign alu_op   = (op == 4'd1) ? 2'b00 :
                    (op == 4'd5) ? 2'b01 :
                    (op == 4'd9) ? 2'b10 : 2'b11;

  always_comb begin
    nx = st;
    case (st)
      F1:  nx = F2;
      F2:  nx = mem_ready ? F3 : F2;
      F3:  nx = DEC;
      DEC: nx = is_alu ? OPF : ((is_ld || is_br) ? EA : F1);
      EA:  nx = is_br ? EXE : OPF;
      OPF: nx = is_ld ? (mem_ready ? STR : OPF) : EXE;
      EXE: nx = is_alu ? STR : F1;
      STR: nx = F1;
      default: nx = F1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= F1;
    else        st <= nx;

  assign step = st;

  wire rd_step = (st == F2) || (st == OPF && is_ld);

  assign drv_pc    = rst_n && st == F1;
  assign drv_mdr   = rst_n && (st == F3 || (st == STR && is_ld));
  assign drv_alu   = rst_n && st == STR && is_alu;
  assign drv_addr  = rst_n && st == EA && is_ld;
  assign ld_mar    = rst_n && (st == F1 || (st == EA && is_ld));
  assign mem_rd    = rst_n && rd_step;
  assign ld_mdr    = rst_n && rd_step && mem_ready;
  assign ld_ir     = rst_n && st == F3;
  assign ld_reg    = rst_n && st == STR;
  assign ld_cc     = rst_n && st == STR;
  assign pc_inc    = rst_n && st == F1;
  assign pc_jump   = rst_n && st == EXE && is_br;
  assign addr_base = rst_n && st == EA && op == 4'd6;

  p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_pc, drv_mdr, drv_alu, drv_addr}));

  p_fetch_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_pc |=> (step == 3'd1));

  p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 3'd1 && !mem_ready) |=> (step == 3'd1 && mem_rd));

  p_ir_to_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> (step == 3'd3 && !drv_pc));

  p_store_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_reg |=> drv_pc);

  always_comb
    if (!rst_n)
      p_quiet_r11: assert ({drv_pc, drv_mdr, drv_alu, drv_addr, ld_mar, ld_mdr,
                            ld_ir, ld_reg, ld_cc, pc_inc, pc_jump, mem_rd} == 12'd0);

endmodule

// File: tb/test_instr_seq.sv
module test_instr_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, mem_ready = 1;
  logic [15:0] ir = 16'h0000;
  logic [2:0] step;
  logic drv_pc, drv_mdr, drv_alu, drv_addr, ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc;
  logic pc_inc, pc_jump, mem_rd, addr_base, imm_mode;
  logic [1:0] alu_op;
  logic [15:0] op_hot;
  logic [2:0] dst, sr1, sr2;
  logic [5:0] off6;
  logic [8:0] off9;

  instr_seq i_instr_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {ir, length, path of 3-bit step codes, first step in low bits}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {16'h1283, 4'd7, 24'o0007653210},
    {16'h5A21, 4'd7, 24'o0007653210},
    {16'h9E3F, 4'd7, 24'o0007653210},
    {16'h2405, 4'd7, 24'o0007543210},
    {16'h6A86, 4'd7, 24'o0007543210},
    {16'h0E10, 4'd6, 24'o0000643210},
    {16'hF025, 4'd4, 24'o0000003210}
  };

  function automatic logic [1:0] exp_alu(input logic [3:0] o);
    return (o == 1) ? 2'b00 : (o == 5) ? 2'b01 : (o == 9) ? 2'b10 : 2'b11;
  endfunction

  initial begin
    #(CLK_PERIOD*20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 strobes quiet in reset
    chk("R11", {drv_pc, drv_mdr, drv_alu, drv_addr, ld_mar, ld_mdr, ld_ir, ld_reg,
                ld_cc, pc_inc, pc_jump, mem_rd}, 0);
    rst_n = 1;
    for (int v = 0; v < NV; v++) begin
      logic [3:0] o;
      logic [3:0] len;
      o = VEC[v][43:40];
      len = VEC[v][27:24];
      ir = VEC[v][43:28];
      for (int s = 0; s < len; s++) begin
        logic [2:0] e;
        e = VEC[v][3*s +: 3];
        #1;
        chk("R6/R7/R8/R9 step", step, e);
        chk("R10 one driver", $countones({drv_pc, drv_mdr, drv_alu, drv_addr}) <= 1, 1);
        case (e)
          3'd0: chk("R1", {drv_pc, ld_mar, pc_inc}, 3'b111);
          3'd1: chk("R2", {mem_rd, ld_mdr}, 2'b11);
          3'd2: chk("R3", {drv_mdr, ld_ir}, 2'b11);
          3'd3: begin
            chk("R4", op_hot, 16'd1 << o);
            chk("R5", {dst, sr1, sr2, imm_mode, off6, off9},
                {ir[11:9], ir[8:6], ir[2:0], ir[5], ir[5:0], ir[8:0]});
          end
          3'd4: chk("R7/R8 addr", {addr_base, drv_addr, ld_mar},
                    {o == 4'd6, o != 4'd0, o != 4'd0});
          3'd6: chk("R6/R8 exec", {alu_op, pc_jump}, {exp_alu(o), o == 4'd0});
          3'd7: chk("R6/R7 store", {drv_alu, drv_mdr, ld_reg, ld_cc},
                    {o != 4'd2 && o != 4'd6, o == 4'd2 || o == 4'd6, 2'b11});
          default: ;
        endcase
        @(negedge clk);
      end
    end
    #1 chk("R9 back to fetch", step, 0);

    // R2 wait in fetch 2
    ir = 16'h1283;
    @(negedge clk);
    mem_ready = 0;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R2 hold", {step, mem_rd, ld_mdr}, {3'd1, 1'b1, 1'b0});
      @(negedge clk);
    end
    mem_ready = 1;
    #1 chk("R2 release", {step, ld_mdr}, {3'd1, 1'b1});
    @(negedge clk);
    #1 chk("R3 after wait", step, 3'd2);

    // R7 wait in operand read of a load
    rst_n = 0; #1; rst_n = 1;
    ir = 16'h6A86;
    repeat (5) @(negedge clk);
    mem_ready = 0;
    #1 chk("R7 at operand", {step, mem_rd, ld_mdr}, {3'd5, 1'b1, 1'b0});
    @(negedge clk);
    #1 chk("R7 operand hold", step, 3'd5);
    mem_ready = 1;
    @(negedge clk);
    #1 chk("R7 to store", {step, drv_mdr, ld_reg}, {3'd7, 1'b1, 1'b1});

    // R11 reset mid-instruction
    rst_n = 0;
    #1 chk("R11 mid reset", {step, drv_pc, ld_reg, mem_rd}, {3'd0, 3'b000});
    @(negedge clk);
    rst_n = 1;
    #1 chk("R11 restart", {step, drv_pc}, {3'd0, 1'b1});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule